// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and a calendar. It holds seconds, minutes, hours, a day of week, a day of month, a month and a three-digit year. A prescaler counts strobes from a 32768 Hz reference and advances the time once per second. A carry then ripples through the time and date fields.

Software sees every field in BCD and can overwrite any field through a per-field write strobe that shares one data bus. Writes take effect only while the RTC enable input is high. The month rollover follows the Gregorian leap-year rule. The block raises a one-cycle strobe each time the time advances, so alarm-compare logic can sample the new value. Bus decoding and interrupt handling sit outside the block.

Top module: `bcd_calendar`

## Requirements
- R1: While `rtc_en_i` is high, the time advances by one second on every `REF_TICKS`-th cycle that has `ref_tick_i` high (default 32768). The strobe count restarts from zero whenever `rtc_en_i` is low, so nothing advances while the enable is low.
- R2: Seconds count 0 to 59, then return to 0 and carry into minutes. Minutes do the same and carry into hours. Hours count 0 to 23, then return to 0 and carry into the date.
- R3: The day of week steps once per day carry and wraps from 6 to 0.
- R4: When a day carry arrives with the day of month at the month's length or above, the day of month returns to 1 and the month advances. Month lengths from January to December are 31,28,31,30,31,30,31,31,30,31,30,31.
- R5: The year field Y counts years since 1900, in the range 0 to 999. February has 29 days when Y mod 4 = 0 and either Y mod 100 ≠ 0 or Y mod 400 = 100. Examples are Y=100 (2000) and Y=500 (2400). Y=200 (2100) and Y=97 are not leap years.
- R6: A carry out of December sets the month to January and increments the year. Year 999 wraps to 0.
- R7: While `rtc_en_i` is low, field writes are ignored and every readback output holds its value.
- R8: The encodings are BCD. Seconds, minutes, hours, day of week and day of month use two digits in `wr_data_i[7:0]` and in their outputs. The month uses two digits with values 1 to 12. The year uses three digits in `wr_data_i[11:0]` and `year_o`, with the hundreds digit in bits 11:8.
- R9: A write to a field in the same cycle as a carry into that field wins for that field. The carry out of the field is still taken from its old value.
- R10: Reset sets 00:00:00, day of week 6, day 1, month 1, year 0x100 (2000), and `sec_tick_o` low.
- R11: `sec_tick_o` is high for exactly one cycle, the first cycle in which the advanced time is visible on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | One-cycle strobe at the reference rate |
| rtc_en_i | input | 1 | Enables counting and field writes |
| wr_sec_i | input | 1 | Write strobe for seconds |
| wr_min_i | input | 1 | Write strobe for minutes |
| wr_hour_i | input | 1 | Write strobe for hours |
| wr_wday_i | input | 1 | Write strobe for day of week |
| wr_mday_i | input | 1 | Write strobe for day of month |
| wr_mon_i | input | 1 | Write strobe for month |
| wr_year_i | input | 1 | Write strobe for year |
| wr_data_i | input | 12 | BCD write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD |
| wday_o | output | 8 | Day of week, BCD |
| mday_o | output | 8 | Day of month, BCD |
| mon_o | output | 8 | Month 1 to 12, BCD |
| year_o | output | 12 | Year, three BCD digits |
| sec_tick_o | output | 1 | One-cycle pulse after each advance |

## Verification
The hardest case to reach from the ports is a field write that lands in exactly the cycle of a one-second carry. Only the prescaler phase decides when that cycle comes. The bench first runs one full second, which leaves the prescaler at a known zero phase. It then holds the reference strobe low while it loads the time, applies exactly `REF_TICKS-1` strobes, and asserts the write together with the final strobe. The bench also covers the leap-year rule at its century exceptions by loading 28 February, 23:59:59, in each chosen year and letting one second pass.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  localparam int unsigned HMS_W  = 6;
  localparam int unsigned WDAY_W = 3;
  localparam int unsigned MDAY_W = 5;
  localparam int unsigned MON_W  = 4;
  localparam int unsigned YEAR_W = 10;

  localparam logic [YEAR_W-1:0] YEAR_LAST = YEAR_W'(999);
  localparam logic [YEAR_W-1:0] YEAR_RST  = YEAR_W'(100);
  localparam logic [WDAY_W-1:0] WDAY_RST  = WDAY_W'(6);

  function automatic logic [7:0] bin_to_bcd2(input logic [6:0] v);
    return {4'(v / 7'd10), 4'(v % 7'd10)};
  endfunction

  function automatic logic [6:0] bcd2_to_bin(input logic [7:0] b);
    return {3'b0, b[7:4]} * 7'd10 + {3'b0, b[3:0]};
  endfunction

  function automatic logic [11:0] bin_to_bcd3(input logic [9:0] v);
    return {4'(v / 10'd100), bin_to_bcd2(7'(v % 10'd100))};
  endfunction

  function automatic logic [9:0] bcd3_to_bin(input logic [11:0] b);
    return {6'b0, b[11:8]} * 10'd100 + {3'b0, bcd2_to_bin(b[7:0])};
  endfunction

  // year counted from 1900
  function automatic logic is_leap(input logic [9:0] y);
    return (y % 10'd4 == 10'd0) &&
           ((y % 10'd100 != 10'd0) || (y % 10'd400 == 10'd100));
  endfunction

  // month is 0-based
  function automatic logic [4:0] month_len(input logic [3:0] m, input logic leap);
    case (m)
      4'd1:                      return leap ? 5'd29 : 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int unsigned TICKS = 32768,
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_tick_i,
  output logic adv_o
);

  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign adv_o = en_i && ref_tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!en_i)      cnt_q <= '0;
    else if (ref_tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  AST_IDLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0); // R1
  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ref_tick_i && !adv_o |=> cnt_q == $past(cnt_q) + 1'b1); // R1

endmodule

// File: rtl/cal_wrap_counter.sv
module cal_wrap_counter #(
  parameter int unsigned W    = 6,
  parameter int unsigned LAST = 59
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] val_o,
  output logic         carry_o
);

  logic [W-1:0] val_q;
  logic         at_end;

  assign at_end  = val_q >= W'(LAST);
  assign carry_o = inc_i && at_end;
  assign val_o   = val_q;

  // load wins over increment; carry still from old value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= '0;
    else if (ld_i)   val_q <= ld_val_i;
    else if (inc_i)  val_q <= at_end ? '0 : val_q + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !ld_i && val_o >= W'(LAST) |=> val_o == '0); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !ld_i |=> $stable(val_o)); // R7
  AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> val_o == $past(ld_val_i)); // R9

endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
  import bcd_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              day_inc_i,
  input  logic              wr_wday_i,
  input  logic              wr_mday_i,
  input  logic              wr_mon_i,
  input  logic              wr_year_i,
  input  logic [WDAY_W-1:0] wday_val_i,
  input  logic [MDAY_W-1:0] mday_val_i,
  input  logic [MON_W-1:0]  mon_val_i,
  input  logic [YEAR_W-1:0] year_val_i,
  output logic [WDAY_W-1:0] wday_o,
  output logic [MDAY_W-1:0] mday_o,
  output logic [MON_W-1:0]  mon_o,
  output logic [YEAR_W-1:0] year_o
);

  logic [WDAY_W-1:0] wday_q;
  logic [MDAY_W-1:0] mday_q, dim;
  logic [MON_W-1:0]  mon_q;
  logic [YEAR_W-1:0] year_q;
  logic              mday_roll, mon_roll;

  assign dim       = month_len(mon_q, is_leap(year_q));
  assign mday_roll = day_inc_i && (mday_q >= dim);
  assign mon_roll  = mday_roll && (mon_q >= MON_W'(11));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wday_q <= WDAY_RST;
      mday_q <= MDAY_W'(1);
      mon_q  <= '0;
      year_q <= YEAR_RST;
    end else begin
      if (wr_wday_i)      wday_q <= wday_val_i;
      else if (day_inc_i) wday_q <= (wday_q >= WDAY_W'(6)) ? '0 : wday_q + 1'b1;

      if (wr_mday_i)      mday_q <= mday_val_i;
      else if (day_inc_i) mday_q <= mday_roll ? MDAY_W'(1) : mday_q + 1'b1;

      if (wr_mon_i)       mon_q <= mon_val_i;
      else if (mday_roll) mon_q <= mon_roll ? '0 : mon_q + 1'b1;

      if (wr_year_i)      year_q <= year_val_i;
      else if (mon_roll)  year_q <= (year_q >= YEAR_LAST) ? '0 : year_q + 1'b1;
    end
  end

  assign wday_o = wday_q;
  assign mday_o = mday_q;
  assign mon_o  = mon_q;
  assign year_o = year_q;

  AST_WDAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_inc_i && !wr_wday_i && wday_q == WDAY_W'(6) |=> wday_q == '0); // R3
  AST_MDAY_ROLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_inc_i && !wr_mday_i && mday_q == dim |=> mday_q == MDAY_W'(1)); // R4
  AST_FEB_LEAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_inc_i && !wr_mday_i && !wr_mon_i && mon_q == MON_W'(1) &&
    mday_q == MDAY_W'(28) && is_leap(year_q)
    |=> mday_q == MDAY_W'(29) && mon_q == MON_W'(1)); // R5
  AST_YEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_inc_i && !wr_mday_i && !wr_mon_i && !wr_year_i &&
    mon_q == MON_W'(11) && mday_q == MDAY_W'(31)
    |=> mon_q == '0 &&
        year_q == (($past(year_q) >= YEAR_LAST) ? '0 : $past(year_q) + 1'b1)); // R6

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int unsigned REF_TICKS = 32768
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_tick_i,
  input  logic        rtc_en_i,
  input  logic        wr_sec_i,
  input  logic        wr_min_i,
  input  logic        wr_hour_i,
  input  logic        wr_wday_i,
  input  logic        wr_mday_i,
  input  logic        wr_mon_i,
  input  logic        wr_year_i,
  input  logic [11:0] wr_data_i,
  output logic [7:0]  sec_o,
  output logic [7:0]  min_o,
  output logic [7:0]  hour_o,
  output logic [7:0]  wday_o,
  output logic [7:0]  mday_o,
  output logic [7:0]  mon_o,
  output logic [11:0] year_o,
  output logic        sec_tick_o
);

  localparam int unsigned NUM_HMS = 3;
  localparam int unsigned HMS_LAST [NUM_HMS] = '{59, 59, 23};

  logic               sec_adv, sec_tick_q;
  logic [NUM_HMS-1:0] hms_inc, hms_carry, hms_ld;
  logic [HMS_W-1:0]   hms_val [NUM_HMS];
  logic [6:0]         wr_bin2;
  logic [WDAY_W-1:0]  wday_q;
  logic [MDAY_W-1:0]  mday_q;
  logic [MON_W-1:0]   mon_q;
  logic [YEAR_W-1:0]  year_q;

  cal_prescaler #(.TICKS(REF_TICKS)) u_prescaler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (rtc_en_i),
    .ref_tick_i (ref_tick_i),
    .adv_o      (sec_adv)
  );

  assign wr_bin2 = bcd2_to_bin(wr_data_i[7:0]);
  assign hms_inc = {hms_carry[NUM_HMS-2:0], sec_adv};
  assign hms_ld  = {wr_hour_i, wr_min_i, wr_sec_i} & {NUM_HMS{rtc_en_i}};

  for (genvar g = 0; g < NUM_HMS; g++) begin : g_hms
    cal_wrap_counter #(.W(HMS_W), .LAST(HMS_LAST[g])) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .inc_i    (hms_inc[g]),
      .ld_i     (hms_ld[g]),
      .ld_val_i (HMS_W'(wr_bin2)),
      .val_o    (hms_val[g]),
      .carry_o  (hms_carry[g])
    );
  end

  cal_date_unit u_date (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .day_inc_i  (hms_carry[NUM_HMS-1]),
    .wr_wday_i  (wr_wday_i && rtc_en_i),
    .wr_mday_i  (wr_mday_i && rtc_en_i),
    .wr_mon_i   (wr_mon_i && rtc_en_i),
    .wr_year_i  (wr_year_i && rtc_en_i),
    .wday_val_i (WDAY_W'(wr_bin2)),
    .mday_val_i (MDAY_W'(wr_bin2)),
    .mon_val_i  (MON_W'(wr_bin2 - 7'd1)),
    .year_val_i (bcd3_to_bin(wr_data_i)),
    .wday_o     (wday_q),
    .mday_o     (mday_q),
    .mon_o      (mon_q),
    .year_o     (year_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_tick_q <= 1'b0;
    else         sec_tick_q <= sec_adv;
  end

  assign sec_o      = bin_to_bcd2({1'b0, hms_val[0]});
  assign min_o      = bin_to_bcd2({1'b0, hms_val[1]});
  assign hour_o     = bin_to_bcd2({1'b0, hms_val[2]});
  assign wday_o     = bin_to_bcd2({4'b0, wday_q});
  assign mday_o     = bin_to_bcd2({2'b0, mday_q});
  assign mon_o      = bin_to_bcd2({3'b0, mon_q} + 7'd1);
  assign year_o     = bin_to_bcd3(year_q);
  assign sec_tick_o = sec_tick_q;

  AST_OFF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rtc_en_i |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
    $stable(wday_o) && $stable(mday_o) && $stable(mon_o) && $stable(year_o)); // R7
  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o); // R11
  AST_TICK_ONLY_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rtc_en_i |=> !sec_tick_o); // R1

endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 4;
  localparam int WDOG       = 50000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        rtc_en = 1'b0;
  logic        wr_sec = 1'b0, wr_min = 1'b0, wr_hour = 1'b0, wr_wday = 1'b0;
  logic        wr_mday = 1'b0, wr_mon = 1'b0, wr_year = 1'b0;
  logic [11:0] wr_data = '0;
  logic [7:0]  sec, min, hour, wday, mday, mon;
  logic [11:0] year;
  logic        sec_tick;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_calendar #(.REF_TICKS(TICKS)) u_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .ref_tick_i(ref_tick), .rtc_en_i(rtc_en),
    .wr_sec_i(wr_sec), .wr_min_i(wr_min), .wr_hour_i(wr_hour),
    .wr_wday_i(wr_wday), .wr_mday_i(wr_mday), .wr_mon_i(wr_mon),
    .wr_year_i(wr_year), .wr_data_i(wr_data),
    .sec_o(sec), .min_o(min), .hour_o(hour), .wday_o(wday), .mday_o(mday),
    .mon_o(mon), .year_o(year), .sec_tick_o(sec_tick)
  );

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // fields: 0 sec 1 min 2 hour 3 wday 4 mday 5 mon 6 year
  task automatic wr_field(input int f, input logic [11:0] d);
    wr_data = d;
    case (f)
      0: wr_sec = 1'b1;  1: wr_min = 1'b1;  2: wr_hour = 1'b1;
      3: wr_wday = 1'b1; 4: wr_mday = 1'b1; 5: wr_mon = 1'b1;
      default: wr_year = 1'b1;
    endcase
    @(negedge clk);
    {wr_sec, wr_min, wr_hour, wr_wday, wr_mday, wr_mon, wr_year} = '0;
  endtask

  task automatic set_time(input logic [11:0] y, input logic [7:0] mo, input logic [7:0] d,
                          input logic [7:0] wd, input logic [7:0] h, input logic [7:0] mi,
                          input logic [7:0] s);
    wr_field(6, y);  wr_field(5, {4'h0, mo}); wr_field(4, {4'h0, d});
    wr_field(3, {4'h0, wd}); wr_field(2, {4'h0, h}); wr_field(1, {4'h0, mi});
    wr_field(0, {4'h0, s});
  endtask

  task automatic run_second(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      ref_tick = 1'b1;
      @(negedge clk);
      n++;
      if (sec_tick) break;
    end
    ref_tick = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 sec", {4'h0, sec}, 12'h000);
    check("R10 min", {4'h0, min}, 12'h000);
    check("R10 hour", {4'h0, hour}, 12'h000);
    check("R10 wday", {4'h0, wday}, 12'h006);
    check("R10 mday", {4'h0, mday}, 12'h001);
    check("R10 mon", {4'h0, mon}, 12'h001);
    check("R10 year", year, 12'h100);
    check("R10 tick", {11'h0, sec_tick}, 12'h000);
  endtask

  task automatic t_prescale;
    int n;
    rtc_en = 1'b1;
    run_second(n);
    check("R1 strobes per second", 12'(n), 12'(TICKS));
    check("R1 sec advanced", {4'h0, sec}, 12'h001);
    @(negedge clk);
    check("R11 tick single cycle", {11'h0, sec_tick}, 12'h000);
    repeat (5) @(negedge clk);
    check("R1 no strobe no advance", {4'h0, sec}, 12'h001);
    ref_tick = 1'b1;
    repeat (2) @(negedge clk);
    ref_tick = 1'b0;
    rtc_en = 1'b0;
    @(negedge clk);
    rtc_en = 1'b1;
    run_second(n);
    check("R1 count restarts on enable", 12'(n), 12'(TICKS));
    check("R1 sec after restart", {4'h0, sec}, 12'h002);
  endtask

  task automatic t_bcd_write;
    set_time(12'h987, 8'h11, 8'h25, 8'h03, 8'h19, 8'h48, 8'h37);
    check("R8 sec", {4'h0, sec}, 12'h037);
    check("R8 min", {4'h0, min}, 12'h048);
    check("R8 hour", {4'h0, hour}, 12'h019);
    check("R8 wday", {4'h0, wday}, 12'h003);
    check("R8 mday", {4'h0, mday}, 12'h025);
    check("R8 mon", {4'h0, mon}, 12'h011);
    check("R8 year", year, 12'h987);
  endtask

  task automatic t_hms_carry;
    int n;
    set_time(12'h123, 8'h06, 8'h10, 8'h02, 8'h10, 8'h59, 8'h59);
    run_second(n);
    check("R2 sec wrap", {4'h0, sec}, 12'h000);
    check("R2 min wrap", {4'h0, min}, 12'h000);
    check("R2 hour step", {4'h0, hour}, 12'h011);
    check("R2 date untouched", {4'h0, mday}, 12'h010);
    set_time(12'h123, 8'h06, 8'h10, 8'h02, 8'h10, 8'h20, 8'h30);
    run_second(n);
    check("R2 plain second", {4'h0, sec}, 12'h031);
    check("R2 min held", {4'h0, min}, 12'h020);
  endtask

  task automatic day_end(input string tag, input logic [11:0] y, input logic [7:0] mo,
                         input logic [7:0] d, input logic [11:0] ey, input logic [7:0] emo,
                         input logic [7:0] ed);
    int n;
    set_time(y, mo, d, 8'h02, 8'h23, 8'h59, 8'h59);
    run_second(n);
    check({tag, " mday"}, {4'h0, mday}, {4'h0, ed});
    check({tag, " mon"}, {4'h0, mon}, {4'h0, emo});
    check({tag, " year"}, year, ey);
  endtask

  task automatic t_month_len;
    day_end("R4 apr30", 12'h123, 8'h04, 8'h30, 12'h123, 8'h05, 8'h01);
    day_end("R4 apr29", 12'h123, 8'h04, 8'h29, 12'h123, 8'h04, 8'h30);
    day_end("R4 jan31", 12'h123, 8'h01, 8'h31, 12'h123, 8'h02, 8'h01);
    day_end("R4 sep30", 12'h123, 8'h09, 8'h30, 12'h123, 8'h10, 8'h01);
  endtask

  task automatic t_leap;
    day_end("R5 y100 feb28", 12'h100, 8'h02, 8'h28, 12'h100, 8'h02, 8'h29);
    day_end("R5 y100 feb29", 12'h100, 8'h02, 8'h29, 12'h100, 8'h03, 8'h01);
    day_end("R5 y200 feb28", 12'h200, 8'h02, 8'h28, 12'h200, 8'h03, 8'h01);
    day_end("R5 y096 feb28", 12'h096, 8'h02, 8'h28, 12'h096, 8'h02, 8'h29);
    day_end("R5 y097 feb28", 12'h097, 8'h02, 8'h28, 12'h097, 8'h03, 8'h01);
    day_end("R5 y500 feb28", 12'h500, 8'h02, 8'h28, 12'h500, 8'h02, 8'h29);
  endtask

  task automatic t_year_end;
    int n;
    set_time(12'h199, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59);
    run_second(n);
    check("R6 mon wrap", {4'h0, mon}, 12'h001);
    check("R6 year step", year, 12'h200);
    check("R4 mday to 1", {4'h0, mday}, 12'h001);
    check("R3 wday wrap", {4'h0, wday}, 12'h000);
    check("R2 hour wrap", {4'h0, hour}, 12'h000);
    day_end("R6 y999", 12'h999, 8'h12, 8'h31, 12'h000, 8'h01, 8'h01);
    set_time(12'h123, 8'h05, 8'h05, 8'h03, 8'h23, 8'h59, 8'h59);
    run_second(n);
    check("R3 wday step", {4'h0, wday}, 12'h004);
  endtask

  task automatic t_locked;
    set_time(12'h123, 8'h05, 8'h05, 8'h03, 8'h08, 8'h07, 8'h15);
    rtc_en = 1'b0;
    @(negedge clk);
    wr_field(0, 12'h042);
    wr_field(6, 12'h555);
    wr_field(5, 12'h009);
    check("R7 sec write ignored", {4'h0, sec}, 12'h015);
    check("R7 year write ignored", year, 12'h123);
    check("R7 mon write ignored", {4'h0, mon}, 12'h005);
    ref_tick = 1'b1;
    repeat (3 * TICKS) @(negedge clk);
    ref_tick = 1'b0;
    check("R1 no advance when off", {4'h0, sec}, 12'h015);
    check("R1 no tick when off", {11'h0, sec_tick}, 12'h000);
    rtc_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_priority;
    int n;
    run_second(n);  // prescaler phase now zero
    set_time(12'h123, 8'h05, 8'h05, 8'h03, 8'h05, 8'h10, 8'h59);
    ref_tick = 1'b1;
    repeat (TICKS - 1) @(negedge clk);
    wr_sec = 1'b1;
    wr_data = 12'h030;
    @(negedge clk);
    wr_sec = 1'b0;
    ref_tick = 1'b0;
    check("R9 write wins", {4'h0, sec}, 12'h030);
    check("R9 carry from old value", {4'h0, min}, 12'h011);
    check("R11 tick with new time", {11'h0, sec_tick}, 12'h001);
    @(negedge clk);
    check("R11 tick drops", {11'h0, sec_tick}, 12'h000);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_bcd_write();
    t_hms_carry();
    t_month_len();
    t_leap();
    t_year_end();
    t_locked();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule